// File: doc/BRIEF.md
# Doubleword Shift and Rotate Unit

This combinational unit performs the shift and rotate operations of a 64-bit integer datapath. Each cycle it receives a 6-bit function selector, the 5-bit immediate shift field, the 5-bit source-register index field, the 64-bit operand to shift and the 64-bit value of the source register. It returns the shifted or rotated operand, together with a flag that marks an unsupported selector. There is no internal state. The surrounding pipeline registers the inputs and outputs as it needs.

Two operand sizes are covered. Word operations act on the low 32 bits of the operand. Their 32-bit result is always sign-extended to 64 bits, and this holds for logical right shifts and rotates as well. Doubleword operations act on the full 64 bits. The shift amount comes from one of three places: the immediate field, the immediate field plus 32, or the low bits of the source-register value. On three right-shift selectors, an instruction field that would otherwise be zero turns the logical shift into a right rotate.

Top module: `shift_unit`

## Requirements
- R1: Selector 0x00 shifts the low 32 bits left by the immediate field, and selector 0x04 shifts them left by the variable amount. Both keep 32 bits and sign-extend bit 31. All-zero inputs give a zero result with the flag clear.
- R2: Selector 0x02 with the index field equal to 0 is a 32-bit logical right shift by the immediate field, sign-extended.
- R3: Selector 0x02 with the index field equal to 1 is a 32-bit right rotate by the immediate field, sign-extended.
- R4: Selector 0x06 is a 32-bit logical right shift by the variable amount when the immediate field is 0, and a 32-bit right rotate when it is 1. Both results are sign-extended.
- R5: Selectors 0x03 (immediate amount) and 0x07 (variable amount) are 32-bit arithmetic right shifts, sign-extended.
- R6: Selectors 0x38, 0x3A and 0x3B shift all 64 bits by the immediate field. They shift left, logical right and arithmetic right, in that order.
- R7: Selectors 0x3C, 0x3E and 0x3F perform the same three 64-bit shifts by the immediate field plus 32, which gives amounts from 32 to 63.
- R8: Selectors 0x14 and 0x17 are 64-bit left and arithmetic right shifts by the variable amount. Selector 0x16 is a 64-bit logical right shift by the variable amount when the immediate field is 0, and a 64-bit right rotate when it is 1.
- R9: The variable amount uses only bits 4:0 of the source value for word operations and bits 5:0 for doubleword operations. Higher bits have no effect.
- R10: Any selector not listed, and selectors 0x02, 0x06 and 0x16 with a rotate-select field above 1, give a zero result and raise the flag.
- R11: Every legal word operation produces a result whose bits 63:32 all equal bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_code | input | 6 | Operation selector |
| sa_field | input | 5 | Immediate shift field; rotate select for variable right shifts |
| rs_field | input | 5 | Source-register index field; rotate select for the immediate word right shift |
| rt_value | input | 64 | Operand to be shifted |
| rs_value | input | 64 | Source-register value supplying variable amounts |
| result | output | 64 | Shifted or rotated result |
| bad_func | output | 1 | Unsupported selector or select field |

## Verification
The bench builds the unit with its default sizes of a 32-bit word and a 64-bit doubleword, which are the only sizes that give the selector encoding its meaning. At these sizes all 64 selector codes can be crossed with all 32 immediate values and with index fields 0, 1 and 2. That sweep reaches every rotate-select decision and every boundary amount (0, 31, 32 and 63). Operand patterns with bit 31 set exercise word sign extension. Source values with bits set above the amount field show whether those bits are ignored.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int WORD_W  = 32;
    localparam int DWORD_W = 64;
    localparam int FUNC_W  = 6;
    localparam int FIELD_W = 5;

    // selector codes
    localparam logic [FUNC_W-1:0] F_SLL    = 6'h00;
    localparam logic [FUNC_W-1:0] F_SRL    = 6'h02;
    localparam logic [FUNC_W-1:0] F_SRA    = 6'h03;
    localparam logic [FUNC_W-1:0] F_SLLV   = 6'h04;
    localparam logic [FUNC_W-1:0] F_SRLV   = 6'h06;
    localparam logic [FUNC_W-1:0] F_SRAV   = 6'h07;
    localparam logic [FUNC_W-1:0] F_DSLLV  = 6'h14;
    localparam logic [FUNC_W-1:0] F_DSRLV  = 6'h16;
    localparam logic [FUNC_W-1:0] F_DSRAV  = 6'h17;
    localparam logic [FUNC_W-1:0] F_DSLL   = 6'h38;
    localparam logic [FUNC_W-1:0] F_DSRL   = 6'h3A;
    localparam logic [FUNC_W-1:0] F_DSRA   = 6'h3B;
    localparam logic [FUNC_W-1:0] F_DSLL32 = 6'h3C;
    localparam logic [FUNC_W-1:0] F_DSRL32 = 6'h3E;
    localparam logic [FUNC_W-1:0] F_DSRA32 = 6'h3F;

    typedef enum logic [1:0] {
        SH_LEFT    = 2'd0,
        SH_LOGIC_R = 2'd1,
        SH_ARITH_R = 2'd2,
        SH_ROT_R   = 2'd3
    } sh_kind_e;

    typedef enum logic [1:0] {
        AMT_IMM   = 2'd0,
        AMT_IMM32 = 2'd1,
        AMT_VAR   = 2'd2
    } amt_src_e;

    typedef struct packed {
        sh_kind_e kind;
        logic     word_op;
        amt_src_e src;
        logic     bad;
    } sh_ctl_t;

    function automatic logic [DWORD_W-1:0] sext_word(input logic [WORD_W-1:0] w);
        return {{(DWORD_W-WORD_W){w[WORD_W-1]}}, w};
    endfunction

    // map a 0/1 select field to logical shift or rotate; anything else is unsupported
    function automatic logic sel_ok(input logic [FIELD_W-1:0] f);
        return (f[FIELD_W-1:1] == '0);
    endfunction

endpackage

// File: rtl/sru_decode.sv
module sru_decode
    import sru_pkg::*;
(
    input  logic [FUNC_W-1:0]  func_code,
    input  logic [FIELD_W-1:0] sa_field,
    input  logic [FIELD_W-1:0] rs_field,
    output sh_ctl_t            ctl
);

    always_comb begin
        ctl = '{kind: SH_LEFT, word_op: 1'b0, src: AMT_IMM, bad: 1'b0};
        unique case (func_code)
            F_SLL:  ctl = '{SH_LEFT,    1'b1, AMT_IMM, 1'b0};
            F_SRL: begin
                ctl = '{(rs_field[0] ? SH_ROT_R : SH_LOGIC_R), 1'b1, AMT_IMM, 1'b0};
                ctl.bad = !sel_ok(rs_field);
            end
            F_SRA:  ctl = '{SH_ARITH_R, 1'b1, AMT_IMM, 1'b0};
            F_SLLV: ctl = '{SH_LEFT,    1'b1, AMT_VAR, 1'b0};
            F_SRLV: begin
                ctl = '{(sa_field[0] ? SH_ROT_R : SH_LOGIC_R), 1'b1, AMT_VAR, 1'b0};
                ctl.bad = !sel_ok(sa_field);
            end
            F_SRAV:  ctl = '{SH_ARITH_R, 1'b1, AMT_VAR, 1'b0};
            F_DSLLV: ctl = '{SH_LEFT,    1'b0, AMT_VAR, 1'b0};
            F_DSRLV: begin
                ctl = '{(sa_field[0] ? SH_ROT_R : SH_LOGIC_R), 1'b0, AMT_VAR, 1'b0};
                ctl.bad = !sel_ok(sa_field);
            end
            F_DSRAV:  ctl = '{SH_ARITH_R, 1'b0, AMT_VAR,   1'b0};
            F_DSLL:   ctl = '{SH_LEFT,    1'b0, AMT_IMM,   1'b0};
            F_DSRL:   ctl = '{SH_LOGIC_R, 1'b0, AMT_IMM,   1'b0};
            F_DSRA:   ctl = '{SH_ARITH_R, 1'b0, AMT_IMM,   1'b0};
            F_DSLL32: ctl = '{SH_LEFT,    1'b0, AMT_IMM32, 1'b0};
            F_DSRL32: ctl = '{SH_LOGIC_R, 1'b0, AMT_IMM32, 1'b0};
            F_DSRA32: ctl = '{SH_ARITH_R, 1'b0, AMT_IMM32, 1'b0};
            default:  ctl.bad = 1'b1;
        endcase
    end

    always_comb begin
        // R11
        word_sel_chk: assert (!(ctl.word_op && !ctl.bad) || func_code[FUNC_W-1:FUNC_W-2] == 2'b00)
            else $error("word operation decoded from a doubleword selector");
        // R3
        rot_word_chk: assert (!(ctl.kind == SH_ROT_R && !ctl.bad && ctl.word_op)
                              || func_code == F_SRL || func_code == F_SRLV)
            else $error("word rotate from unexpected selector");
    end

endmodule

// File: rtl/sru_amount.sv
module sru_amount
    import sru_pkg::*;
#(
    parameter int DW = DWORD_W,
    parameter int WW = WORD_W,
    localparam int LOG_DW = $clog2(DW),
    localparam int LOG_WW = $clog2(WW)
) (
    input  sh_ctl_t            ctl,
    input  logic [FIELD_W-1:0] sa_field,
    input  logic [DW-1:0]      rs_value,
    output logic [LOG_DW-1:0]  amount
);

    always_comb begin
        unique case (ctl.src)
            AMT_IMM:   amount = LOG_DW'(sa_field);
            AMT_IMM32: amount = LOG_DW'(sa_field) + LOG_DW'(WW);
            default:   amount = ctl.word_op ? LOG_DW'(rs_value[LOG_WW-1:0])
                                            : rs_value[LOG_DW-1:0];
        endcase
    end

    always_comb begin
        // R9
        word_amt_range_chk: assert (ctl.bad || !ctl.word_op || amount < LOG_DW'(WW))
            else $error("word shift amount beyond word width");
        // R7
        plus32_range_chk: assert (ctl.bad || ctl.src != AMT_IMM32 || amount >= LOG_DW'(WW))
            else $error("+32 amount below 32");
    end

endmodule

// File: rtl/sru_core.sv
module sru_core
    import sru_pkg::*;
#(
    parameter int W = DWORD_W,
    localparam int LOG_W = $clog2(W)
) (
    input  logic [W-1:0]     x,
    input  logic [LOG_W-1:0] a,
    input  sh_kind_e         kind,
    output logic [W-1:0]     y
);

    logic [2*W-1:0] doubled;
    logic [2*W-1:0] doubled_sh;

    assign doubled    = {x, x};
    assign doubled_sh = doubled >> a;

    always_comb begin
        unique case (kind)
            SH_LEFT:    y = x << a;
            SH_LOGIC_R: y = x >> a;
            SH_ARITH_R: y = W'($signed(x) >>> a);
            default:    y = doubled_sh[W-1:0];
        endcase
    end

    always_comb begin
        // R5
        arith_sign_chk: assert (kind != SH_ARITH_R || y[W-1] == x[W-1])
            else $error("arithmetic shift lost the sign");
        // R3
        rot_pop_chk: assert (kind != SH_ROT_R || $countones(y) == $countones(x))
            else $error("rotate changed bit population");
    end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import sru_pkg::*;
#(
    parameter int DW = DWORD_W,
    parameter int WW = WORD_W,
    localparam int LOG_DW = $clog2(DW),
    localparam int LOG_WW = $clog2(WW)
) (
    input  logic [FUNC_W-1:0]  func_code,
    input  logic [FIELD_W-1:0] sa_field,
    input  logic [FIELD_W-1:0] rs_field,
    input  logic [DW-1:0]      rt_value,
    input  logic [DW-1:0]      rs_value,
    output logic [DW-1:0]      result,
    output logic               bad_func
);

    sh_ctl_t           ctl;
    logic [LOG_DW-1:0] amount;
    logic [WW-1:0]     word_y;
    logic [DW-1:0]     dword_y;

    sru_decode u_dec (
        .func_code (func_code),
        .sa_field  (sa_field),
        .rs_field  (rs_field),
        .ctl       (ctl)
    );

    sru_amount #(.DW(DW), .WW(WW)) u_amt (
        .ctl      (ctl),
        .sa_field (sa_field),
        .rs_value (rs_value),
        .amount   (amount)
    );

    sru_core #(.W(WW)) u_word (
        .x    (rt_value[WW-1:0]),
        .a    (amount[LOG_WW-1:0]),
        .kind (ctl.kind),
        .y    (word_y)
    );

    sru_core #(.W(DW)) u_dword (
        .x    (rt_value),
        .a    (amount),
        .kind (ctl.kind),
        .y    (dword_y)
    );

    always_comb begin
        if (ctl.bad)          result = '0;
        else if (ctl.word_op) result = {{(DW-WW){word_y[WW-1]}}, word_y};
        else                  result = dword_y;
    end

    assign bad_func = ctl.bad;

    always_comb begin
        // R10
        bad_zero_chk: assert (!bad_func || result == '0)
            else $error("unsupported selector gave nonzero result");
        // R11
        word_sext_chk: assert (bad_func || func_code[FUNC_W-1:FUNC_W-2] != 2'b00
                               || result[DW-1:WW-1] == '0 || result[DW-1:WW-1] == '1)
            else $error("word result not sign-extended");
    end

endmodule

// File: tb/shift_unit_test.sv
module shift_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  func_code;
    logic [4:0]  sa_field;
    logic [4:0]  rs_field;
    logic [63:0] rt_value;
    logic [63:0] rs_value;
    logic [63:0] result;
    logic        bad_func;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    shift_unit uut (
        .func_code (func_code),
        .sa_field  (sa_field),
        .rs_field  (rs_field),
        .rt_value  (rt_value),
        .rs_value  (rs_value),
        .result    (result),
        .bad_func  (bad_func)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            bad = bad + 1;
            $display("FAIL watchdog: run did not complete, got cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right
    function automatic logic [63:0] ref_word(input int kind, input logic [31:0] x, input int a);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            case (kind)
                0: r[i] = (i - a >= 0) ? x[i-a] : 1'b0;
                1: r[i] = (i + a < 32) ? x[i+a] : 1'b0;
                2: r[i] = (i + a < 32) ? x[i+a] : x[31];
                default: r[i] = x[(i+a)%32];
            endcase
        end
        return {{32{r[31]}}, r};
    endfunction

    function automatic logic [63:0] ref_dword(input int kind, input logic [63:0] x, input int a);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) begin
            case (kind)
                0: r[i] = (i - a >= 0) ? x[i-a] : 1'b0;
                1: r[i] = (i + a < 64) ? x[i+a] : 1'b0;
                2: r[i] = (i + a < 64) ? x[i+a] : x[63];
                default: r[i] = x[(i+a)%64];
            endcase
        end
        return r;
    endfunction

    function automatic void model(input logic [5:0] f, input logic [4:0] sa, input logic [4:0] rsf,
                                  input logic [63:0] rt, input logic [63:0] rsv,
                                  output logic [63:0] e, output logic ill, output string tag);
        int sv5 = int'(rsv[4:0]);
        int sv6 = int'(rsv[5:0]);
        int s   = int'(sa);
        logic hi_w = (rsv[63:5] != '0);
        logic hi_d = (rsv[63:6] != '0);
        ill = 1'b0;
        e   = '0;
        tag = "R10";
        case (f)
            6'h00: begin e = ref_word(0, rt[31:0], s); tag = "R1"; end
            6'h02: begin
                if (rsf > 1) ill = 1'b1;
                else begin
                    e = ref_word(rsf == 0 ? 1 : 3, rt[31:0], s);
                    tag = (rsf == 0) ? "R2" : "R3";
                end
            end
            6'h03: begin e = ref_word(2, rt[31:0], s); tag = "R5"; end
            6'h04: begin e = ref_word(0, rt[31:0], sv5); tag = hi_w ? "R9" : "R1"; end
            6'h06: begin
                if (sa > 1) ill = 1'b1;
                else begin
                    e = ref_word(sa == 0 ? 1 : 3, rt[31:0], sv5);
                    tag = hi_w ? "R9" : "R4";
                end
            end
            6'h07: begin e = ref_word(2, rt[31:0], sv5); tag = hi_w ? "R9" : "R5"; end
            6'h14: begin e = ref_dword(0, rt, sv6); tag = hi_d ? "R9" : "R8"; end
            6'h16: begin
                if (sa > 1) ill = 1'b1;
                else begin
                    e = ref_dword(sa == 0 ? 1 : 3, rt, sv6);
                    tag = hi_d ? "R9" : "R8";
                end
            end
            6'h17: begin e = ref_dword(2, rt, sv6); tag = hi_d ? "R9" : "R8"; end
            6'h38: begin e = ref_dword(0, rt, s); tag = "R6"; end
            6'h3A: begin e = ref_dword(1, rt, s); tag = "R6"; end
            6'h3B: begin e = ref_dword(2, rt, s); tag = "R6"; end
            6'h3C: begin e = ref_dword(0, rt, s + 32); tag = "R7"; end
            6'h3E: begin e = ref_dword(1, rt, s + 32); tag = "R7"; end
            6'h3F: begin e = ref_dword(2, rt, s + 32); tag = "R7"; end
            default: ill = 1'b1;
        endcase
    endfunction

    task automatic apply_and_check(input logic [5:0] f, input logic [4:0] sa, input logic [4:0] rsf,
                                   input logic [63:0] rt, input logic [63:0] rsv);
        logic [63:0] e;
        logic        ill;
        string       tag;
        func_code = f; sa_field = sa; rs_field = rsf; rt_value = rt; rs_value = rsv;
        #1;
        model(f, sa, rsf, rt, rsv, e, ill, tag);
        total++;
        if (result !== e || bad_func !== ill) begin
            bad++;
            $display("FAIL %s func=%h sa=%0d rsf=%0d rt=%h rs=%h: got %h/%b expected %h/%b",
                     tag, f, sa, rsf, rt, rsv, result, bad_func, e, ill);
        end
        // R11: word selectors keep bits 63:32 equal to bit 31
        if (!ill && f < 6'h10) begin
            total++;
            if (result[63:32] !== {32{result[31]}}) begin
                bad++;
                $display("FAIL R11 func=%h: got upper=%h expected copies of bit31=%b",
                         f, result[63:32], result[31]);
            end
        end
    endtask

    initial begin
        logic [63:0] rt_pat [4];
        logic [63:0] rs_pat [5];
        rt_pat[0] = 64'h8000_0001_8000_0001;
        rt_pat[1] = 64'h0123_4567_89AB_CDEF;
        rt_pat[2] = 64'hFFFF_FFFF_7FFF_FFFE;
        rt_pat[3] = 64'h7F00_00FF_C3A5_5A3C;
        rs_pat[0] = 64'h0;
        rs_pat[1] = 64'h1F;
        rs_pat[2] = 64'h3F;
        rs_pat[3] = 64'hFFFF_FFFF_FFFF_FFFF;
        rs_pat[4] = 64'hA5A5_0000_0000_0027;

        func_code = '0; sa_field = '0; rs_field = '0; rt_value = '0; rs_value = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: all-zero inputs give zero and a clear flag
        total++;
        if (result !== 64'h0 || bad_func !== 1'b0) begin
            bad++;
            $display("FAIL R1 idle: got %h/%b expected 0/0", result, bad_func);
        end

        for (int f = 0; f < 64; f++)
            for (int s = 0; s < 32; s++)
                for (int r = 0; r < 3; r++)
                    for (int p = 0; p < 4; p++)
                        for (int q = 0; q < 5; q++)
                            apply_and_check(6'(f), 5'(s), 5'(r), rt_pat[p], rs_pat[q]);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule